// File: doc/BRIEF.md
# I2C Bus Clear Recovery Engine

This block frees an I2C bus after a target has been left holding SDA low, for example after a reset in the middle of a read. Software first writes a configuration word and then pulses a load strobe. The strobe copies the word into a working (shadow) copy. Writing the enable bit then starts a clear sequence. The engine toggles SCL through its open-drain output, one phase per bit-timing tick. It watches SDA and can stop pulsing once SDA is released. It can close the sequence with a STOP condition. At the end it reports whether SDA is free and raises a sticky done flag.

The configuration word uses bits [23:16] for the pulse limit, bit 2 for the STOP option, bit 1 for terminate-on-release and bit 0 for enable. Reading the word back returns the staged fields. Bit 0 of the read-back is the live enable, which clears itself when the sequence ends. A typical setting is a limit of 18 with both options on.

Top module: `busclr_engine`

## Requirements
- R1: Threshold and option fields written with `cfg_wr` do not affect a sequence until `load_wr` is pulsed. `load_pend` reads 1 in the cycle after the strobe and 0 one cycle later, once the shadow copy is updated.
- R2: A `cfg_wr` with bit 0 set while idle starts a sequence that uses the shadow copy. Read-back bit 0 is 1 while it runs and returns to 0 when it ends.
- R3: Each pulse holds `scl_oe` high (SCL low) until a tick, then releases SCL until a tick. Without terminate, exactly max(threshold,1) pulses are produced.
- R4: With terminate set, SDA is sampled at the end of each high phase. If SDA reads high, pulsing stops, giving min(max(k,1), max(threshold,1)) pulses when the target frees SDA at the k-th SCL rise.
- R5: With the STOP option set, the pulses are followed by three phases of one tick each: SCL low with SDA driven low, then SCL released with SDA still low, then SDA released while SCL is high. With the option clear, `sda_oe` never asserts.
- R6: `stat_ok` takes the value of `sda_in` at the final cycle of each sequence: 1 when the bus is free, 0 when SDA is still low.
- R7: `irq_done` is set when a sequence ends and stays set until `irq_clr`.
- R8: Writing the enable bit while a sequence runs has no effect on that sequence, and no second sequence follows it.
- R9: During reset and whenever idle, `scl_oe` and `sda_oe` are 0. After reset, the read-back, `load_pend`, `stat_ok` and `irq_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle bit-timing pulse from a prescaler |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word: [23:16] limit, [2] STOP, [1] terminate, [0] enable |
| load_wr | input | 1 | Strobe that copies the staged fields into the shadow copy |
| cfg_rdata | output | 32 | Staged fields, with the live enable in bit 0 |
| load_pend | output | 1 | Load strobe still pending |
| irq_clr | input | 1 | Clears the done flag |
| irq_done | output | 1 | Sticky done flag |
| stat_ok | output | 1 | 1 when the last sequence left SDA high |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The assertions assume that `tick` comes from a free-running prescaler and that `load_wr` is not repeated back to back. They also assume SCL is released whenever `scl_oe` is low, so no clock stretching is modelled. The bench keeps within these limits. It issues ticks at a fixed divide ratio and spaces every strobe at least two cycles apart. It drives SDA from a target model that releases the line after a chosen number of SCL rises. Random limits, option bits and release points are mixed with directed cases: a zero limit, a target that never releases, and an enable write made mid-sequence.

// File: rtl/busclr_pkg.sv
// Shared types and field positions for the bus clear engine.
// Assumes a 32-bit configuration word whose layout software decodes.
package busclr_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned THR_W   = 8;
    localparam int unsigned THR_LSB = 16;
    localparam int unsigned BIT_STOP = 2;
    localparam int unsigned BIT_TERM = 1;
    localparam int unsigned BIT_EN   = 0;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOW, ST_HIGH, ST_STP_LO, ST_STP_HI, ST_STP_REL, ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic             stop;
        logic             term;
    } clr_cfg_t;
endpackage

// File: rtl/busclr_cfg.sv
// Staged and shadow configuration with a self-clearing load strobe.
// Assumes load_wr is a single-cycle strobe; the shadow updates one cycle after it.
module busclr_cfg
    import busclr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              load_wr,
    output clr_cfg_t          stage,
    output clr_cfg_t          shadow,
    output logic              load_pend
);
    // Capture written fields, then copy them to the shadow on a pending load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage     <= '0;
            shadow    <= '0;
            load_pend <= 1'b0;
        end else begin
            if (cfg_wr) begin
                stage.thr  <= cfg_wdata[THR_LSB +: THR_W];
                stage.stop <= cfg_wdata[BIT_STOP];
                stage.term <= cfg_wdata[BIT_TERM];
            end
            if (load_pend) begin
                shadow    <= stage;
                load_pend <= load_wr;
            end else if (load_wr) begin
                load_pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/busclr_seq.sv
// Clear sequencer: SCL pulses, optional early end on SDA release, optional STOP.
// Assumes tick is a one-cycle pulse; each bus phase lasts until the next tick.
module busclr_seq
    import busclr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  clr_cfg_t         cfg,
    input  logic             sda_in,
    output logic             busy,
    output logic             fin,
    output logic             scl_drv,
    output logic             sda_drv,
    output logic [THR_W-1:0] run_thr
);
    seq_state_e        state;
    clr_cfg_t          run;
    logic [THR_W-1:0]  cnt;
    logic [THR_W:0]    cnt_nxt;
    logic              last_pulse;

    // A zero limit is treated as one pulse.
    assign run_thr    = (run.thr == '0) ? {{(THR_W-1){1'b0}}, 1'b1} : run.thr;
    assign cnt_nxt    = {1'b0, cnt} + {{THR_W{1'b0}}, 1'b1};
    assign last_pulse = (run.term && sda_in) || (cnt_nxt >= {1'b0, run_thr});

    // Advance the phase sequence on ticks and count completed pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            run   <= '0;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    run   <= cfg;
                    cnt   <= '0;
                    state <= ST_LOW;
                end
                ST_LOW:  if (tick) state <= ST_HIGH;
                ST_HIGH: if (tick) begin
                    cnt <= cnt_nxt[THR_W-1:0];
                    if (last_pulse) state <= run.stop ? ST_STP_LO : ST_FIN;
                    else            state <= ST_LOW;
                end
                ST_STP_LO:  if (tick) state <= ST_STP_HI;
                ST_STP_HI:  if (tick) state <= ST_STP_REL;
                ST_STP_REL: if (tick) state <= ST_FIN;
                ST_FIN:     state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // Decode bus drives and status strobes from the phase.
    always_comb begin
        busy    = (state != ST_IDLE);
        fin     = (state == ST_FIN);
        scl_drv = (state == ST_LOW) || (state == ST_STP_LO);
        sda_drv = (state == ST_STP_LO) || (state == ST_STP_HI);
    end
endmodule

// File: rtl/busclr_engine.sv
// Top of the bus clear engine: configuration, sequencer, result and done flag.
// Assumes an external open-drain pad: *_oe = 1 pulls the line low.
module busclr_engine
    import busclr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              load_wr,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              load_pend,
    input  logic              irq_clr,
    output logic              irq_done,
    output logic              stat_ok,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe
);
    clr_cfg_t         stage;
    clr_cfg_t         shadow;
    logic             busy;
    logic             fin;
    logic             start;
    logic [THR_W-1:0] run_thr;
    logic             unused_wbits;

    assign unused_wbits = ^{cfg_wdata[WORD_W-1:THR_LSB+THR_W], cfg_wdata[THR_LSB-1:BIT_STOP+1]};
    assign start = cfg_wr && cfg_wdata[BIT_EN] && !busy;

    busclr_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .load_wr(load_wr), .stage(stage), .shadow(shadow), .load_pend(load_pend)
    );

    busclr_seq u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .cfg(shadow),
        .sda_in(sda_in), .busy(busy), .fin(fin), .scl_drv(scl_oe),
        .sda_drv(sda_oe), .run_thr(run_thr)
    );

    // Latch the bus result and raise the sticky done flag at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_ok  <= 1'b0;
            irq_done <= 1'b0;
        end else if (fin) begin
            stat_ok  <= sda_in;
            irq_done <= 1'b1;
        end else if (irq_clr) begin
            irq_done <= 1'b0;
        end
    end

    // Assemble the read-back word with the live enable.
    always_comb begin
        cfg_rdata                     = '0;
        cfg_rdata[THR_LSB +: THR_W]   = stage.thr;
        cfg_rdata[BIT_STOP]           = stage.stop;
        cfg_rdata[BIT_TERM]           = stage.term;
        cfg_rdata[BIT_EN]             = busy;
    end
endmodule

// Protocol checks for busclr_engine, attached through bind below.
module busclr_engine_chk
    import busclr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             load_wr,
    input logic             load_pend,
    input logic             busy,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic             irq_done,
    input logic [THR_W-1:0] run_thr
);
    logic [THR_W:0] pcnt;
    logic           scl_q;

    // Count SCL pulses issued in the current sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt  <= '0;
            scl_q <= 1'b0;
        end else begin
            scl_q <= scl_oe;
            if (!busy) pcnt <= '0;
            else if (scl_oe && !scl_q && !sda_oe) pcnt <= pcnt + 1'b1;
        end
    end

    AST_LOAD_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
        load_pend && !load_wr |=> !load_pend); // R1
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe)); // R9
    AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pcnt <= {1'b0, run_thr})); // R3
    AST_STOP_SDA_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> scl_oe); // R5
    AST_STOP_SDA_UP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_oe); // R5
    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq_done); // R7
endmodule

bind busclr_engine busclr_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .load_wr(load_wr), .load_pend(load_pend),
    .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq_done(irq_done),
    .run_thr(run_thr)
);

// File: tb/busclr_engine_test.sv
// Bench: random and directed clear sequences against a stuck-target model.
module busclr_engine_test;
    localparam int CLK_PER  = 10;
    localparam int TICK_DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        load_wr = 1'b0;
    logic [31:0] cfg_rdata;
    logic        load_pend;
    logic        irq_clr = 1'b0;
    logic        irq_done;
    logic        stat_ok;
    logic        sda_in;
    logic        scl_oe;
    logic        sda_oe;

    int checks = 0;
    int fails  = 0;
    int rise_cnt = 0;
    int pulse_cnt = 0;
    int stop_cnt = 0;
    int tgt_k = 0;
    int tdiv = 0;
    bit scl_was_low = 1'b0;
    bit sda_was_low = 1'b0;
    bit done_flag = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    // Target holds SDA low until it has seen tgt_k SCL rises.
    assign sda_in = !sda_oe && (rise_cnt >= tgt_k);

    busclr_engine uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .load_wr(load_wr), .cfg_rdata(cfg_rdata), .load_pend(load_pend),
        .irq_clr(irq_clr), .irq_done(irq_done), .stat_ok(stat_ok), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always @(negedge clk) begin
        tick <= (tdiv == TICK_DIV - 1);
        tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    end

    always @(negedge clk) begin
        if (!scl_oe && scl_was_low) begin
            rise_cnt++;
            if (!sda_oe) pulse_cnt++;
        end
        if (sda_was_low && !sda_oe && !scl_oe) stop_cnt++;
        scl_was_low = scl_oe;
        sda_was_low = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_pulses(input int thr, input bit term, input int k);
        int te = (thr == 0) ? 1 : thr;
        int kk = (k < 1) ? 1 : k;
        if (!term) return te;
        return (kk < te) ? kk : te;
    endfunction

    function automatic logic [31:0] word(input int thr, input bit stop, input bit term, input bit en);
        return {8'h00, thr[7:0], 13'h0, stop, term, en};
    endfunction

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = w;
        @(negedge clk); cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic do_load();
        @(negedge clk); load_wr = 1'b1;
        @(negedge clk); load_wr = 1'b0;
        chk(load_pend == 1'b1, "R1 load pending", int'(load_pend), 1);
        @(negedge clk);
        chk(load_pend == 1'b0, "R1 load self-clear", int'(load_pend), 0);
    endtask

    // Load one config, start with a different word, check the outcome.
    task automatic run(input int thr, input bit stop, input bit term, input int k,
                       input int sthr, input bit sstop, input bit sterm, input bit poke);
        int ep;
        int wait_n;
        bit ok_exp;
        tgt_k = k;
        rise_cnt = 0; pulse_cnt = 0; stop_cnt = 0;
        write_cfg(word(thr, stop, term, 1'b0));
        do_load();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        write_cfg(word(sthr, sstop, sterm, 1'b1));
        chk(cfg_rdata[0] == 1'b1, "R2 enable reads busy", int'(cfg_rdata[0]), 1);
        if (poke) begin
            repeat (10) @(negedge clk);
            write_cfg(word(200, !stop, !term, 1'b1));
        end
        wait_n = 0;
        while (cfg_rdata[0] && wait_n < 5000) begin @(negedge clk); wait_n++; end
        if (poke) repeat (40) @(negedge clk);
        ep = exp_pulses(thr, term, k);
        ok_exp = ((ep + (stop ? 1 : 0)) >= k);
        chk(cfg_rdata[0] == 1'b0, "R2 enable self-clear", int'(cfg_rdata[0]), 0);
        chk(pulse_cnt == ep, term ? "R4 pulses with terminate" : "R3 pulse count", pulse_cnt, ep);
        chk(stop_cnt == (stop ? 1 : 0), "R5 stop condition", stop_cnt, stop ? 1 : 0);
        chk(stat_ok == ok_exp, "R6 status", int'(stat_ok), int'(ok_exp));
        chk(irq_done == 1'b1, "R7 done flag set", int'(irq_done), 1);
        chk(!scl_oe && !sda_oe, "R9 idle released", int'({scl_oe, sda_oe}), 0);
        if (poke) chk(pulse_cnt == ep && !cfg_rdata[0], "R8 enable while busy ignored", pulse_cnt, ep);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        chk(irq_done == 1'b0, "R7 done flag clear", int'(irq_done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        chk(!scl_oe && !sda_oe, "R9 reset lines", int'({scl_oe, sda_oe}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_rdata == 32'h0, "R9 reset readback", int'(cfg_rdata), 0);
        chk(!load_pend && !irq_done && !stat_ok, "R9 reset flags",
            int'({load_pend, irq_done, stat_ok}), 0);
        write_cfg(word(18, 1'b1, 1'b1, 1'b0));
        chk(cfg_rdata == 32'h0012_0006, "R1 staged readback", int'(cfg_rdata), 32'h0012_0006);
        // Directed corner cases.
        run(18, 1'b1, 1'b1, 5, 18, 1'b1, 1'b1, 1'b0);
        run(0, 1'b0, 1'b0, 3, 7, 1'b1, 1'b1, 1'b0);
        run(255, 1'b1, 1'b1, 1000, 1, 1'b0, 1'b0, 1'b0);
        run(10, 1'b1, 1'b0, 4, 2, 1'b0, 1'b1, 1'b0);
        run(3, 1'b0, 1'b0, 0, 9, 1'b1, 1'b0, 1'b0);
        run(12, 1'b1, 1'b1, 100, 12, 1'b1, 1'b1, 1'b1);
        // Random sequences.
        for (int i = 0; i < 24; i++) begin
            int thr = int'($urandom_range(0, 24));
            int k   = int'($urandom_range(0, 28));
            run(thr, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), k,
                int'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
        end
        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule